// File: doc/BRIEF.md
# Service Bus Master Register File

This block is the software-visible control window of a serial service-bus master. A host reaches it over a 32-bit bus that carries a word address, a read strobe and a write strobe. It holds 185 words of 32 bits. Two of these words are port-enable masks for the low and the high group of ports. Each mask can be loaded whole. It can also be changed bit by bit through a pair of alias addresses, one that sets bits and one that clears them, so that software never needs a read-modify-write.

A version word holds a fixed value after reset. A command word clears the whole file when either of its two top bits is written as one. A reset-status word always reads zero, which reports that no errors are pending. All other words in range store what is written to them. Words past the end of the file read as zero, and writes to them are dropped.

Byte offsets are given below together with their word indices. The word index is the byte offset shifted right by two.

Top module: `svc_master_regs`

## Requirements
- R1: The word index is the byte offset divided by four, and the file spans indices 0 to 184. Read data appears on `rd_data` one clock after the edge that samples `rd_en`, and it stays there until the next edge.
- R2: A write to index 4 (byte 0x010) loads the low enable mask with the write data. A write to index 5 (byte 0x014) does the same for the high mask. A read of index 4 or 5 returns the current mask.
- R3: A write to index 6 (byte 0x018) ORs the data into the low mask. A write to index 7 (byte 0x01C) ORs the data into the high mask.
- R4: A write to index 8 (byte 0x020) clears, in the low mask, each bit that is one in the data. A write to index 9 (byte 0x024) does the same for the high mask.
- R5: Writes to indices 6 to 9 store nothing in those words, so a read of index 6, 7, 8 or 9 returns zero.
- R6: After reset every word reads zero, except index 29 (byte 0x074), which reads 0xE0050101.
- R7: A write to any in-range index not named in R2 to R5, R8 or R9 stores the data unchanged, and index 29 is included.
- R8: A write to index 116 (byte 0x1D0) with bit 31 or bit 30 set returns the whole file, masks included, to the R6 state from the edge that accepts the write. A write to index 116 is never stored, so that word reads zero.
- R9: A write to index 52 (byte 0x0D0) has no effect, and that word reads zero.
- R10: A write to an index of 185 or more changes no word, including the word whose index shares the low address bits. A read of such an index returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| word_addr | input | ADDR_W (10) | Word index of the access |
| wr_data | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Read data, valid one clock after `rd_en` |

## Verification
The assertions assume that the host never raises `rd_en` and `wr_en` in the same cycle. They also assume that a read is judged only in the cycle right after its strobe. The bench drives each access as a single-cycle pulse on one falling edge and drops it on the next. It samples `rd_data` one falling edge after the read, so no two accesses ever overlap. The sweeps cover every in-range index and a set of out-of-range indices that alias the mask words in their low bits.

// File: rtl/svc_regs_pkg.sv
package svc_regs_pkg;
  // Word indices whose behaviour differs from a plain stored word
  localparam int IX_MASK_LO  = 4;
  localparam int IX_MASK_HI  = 5;
  localparam int IX_SET_LO   = 6;
  localparam int IX_SET_HI   = 7;
  localparam int IX_CLR_LO   = 8;
  localparam int IX_CLR_HI   = 9;
  localparam int IX_VERSION  = 29;
  localparam int IX_RST_STAT = 52;
  localparam int IX_RST_CMD  = 116;

  typedef enum logic [2:0] {
    K_PLAIN, K_LOAD, K_SET, K_CLR, K_RST_STAT, K_RST_CMD, K_NONE
  } acc_kind_t;

  typedef enum logic [1:0] {RS_STORE, RS_MASK, RS_ZERO} rd_src_t;
endpackage

// File: rtl/svc_addr_decode.sv
module svc_addr_decode
  import svc_regs_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int NUM_WORDS = 185,
  parameter int IDX_W     = 8
) (
  input  logic [ADDR_W-1:0] word_addr,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range,
  output logic              lane,
  output acc_kind_t         kind
);
  always_comb begin
    in_range = word_addr < ADDR_W'(NUM_WORDS);
    idx      = word_addr[IDX_W-1:0];
    lane     = word_addr[0];
    kind     = K_PLAIN;
    if (!in_range) begin
      kind = K_NONE;
    end else begin
      case (word_addr)
        ADDR_W'(IX_MASK_LO), ADDR_W'(IX_MASK_HI): kind = K_LOAD;
        ADDR_W'(IX_SET_LO),  ADDR_W'(IX_SET_HI):  kind = K_SET;
        ADDR_W'(IX_CLR_LO),  ADDR_W'(IX_CLR_HI):  kind = K_CLR;
        ADDR_W'(IX_RST_STAT):                     kind = K_RST_STAT;
        ADDR_W'(IX_RST_CMD):                      kind = K_RST_CMD;
        default:                                  kind = K_PLAIN;
      endcase
    end
  end
endmodule

// File: rtl/svc_word_store.sv
module svc_word_store #(
  parameter int NUM_WORDS = 185,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_word,
  output logic              rd_valid
);
  // Plain RAM array without reset, so it can map to block RAM
  logic [DATA_W-1:0]    mem [NUM_WORDS];
  // One bit per word: set once written since the last clear
  logic [NUM_WORDS-1:0] written;

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wr_data;
    if (rd_en) rd_word <= mem[idx];
  end

  always_ff @(posedge clk) begin
    if (clear)      written      <= '0;
    else if (wr_en) written[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_valid <= 1'b0;
    else if (rd_en) rd_valid <= written[idx];
  end
endmodule

// File: rtl/svc_port_masks.sv
module svc_port_masks
  import svc_regs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                clear,
  input  logic                wr_en,
  input  logic                lane,
  input  acc_kind_t           kind,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [2*DATA_W-1:0] masks
);
  localparam int LANES = 2;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (clear) begin
        q <= '0;
      end else if (wr_en && lane == 1'(g)) begin
        case (kind)
          K_LOAD:  q <= wr_data;
          K_SET:   q <= q | wr_data;
          K_CLR:   q <= q & ~wr_data;
          default: q <= q;
        endcase
      end
    end
    assign masks[g*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/svc_master_regs.sv
module svc_master_regs
  import svc_regs_pkg::*;
#(
  parameter int          ADDR_W       = 10,
  parameter int          DATA_W       = 32,
  parameter int          NUM_WORDS    = 185,
  parameter logic [31:0] VERSION_WORD = 32'hE005_0101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = $clog2(NUM_WORDS);

  logic [IDX_W-1:0]    idx;
  logic                in_range;
  logic                lane;
  acc_kind_t           kind;
  logic                soft_rst;
  logic                clear;
  logic [DATA_W-1:0]   st_word;
  logic                st_valid;
  logic [2*DATA_W-1:0] masks;
  logic [DATA_W-1:0]   mask_lo;
  logic [DATA_W-1:0]   mask_hi;
  rd_src_t             src_q;
  logic                ver_q;
  logic [DATA_W-1:0]   mask_rd_q;

  svc_addr_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_dec (
    .word_addr(word_addr), .idx(idx), .in_range(in_range), .lane(lane), .kind(kind)
  );

  // Either top bit of a command write clears the file
  assign soft_rst = wr_en && kind == K_RST_CMD &&
                    (wr_data[DATA_W-1] || wr_data[DATA_W-2]);
  assign clear    = rst || soft_rst;

  svc_word_store #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .clear(clear),
    .wr_en(wr_en && kind == K_PLAIN),
    .rd_en(rd_en && in_range),
    .idx(idx), .wr_data(wr_data),
    .rd_word(st_word), .rd_valid(st_valid)
  );

  svc_port_masks #(.DATA_W(DATA_W)) u_masks (
    .clk(clk), .clear(clear), .wr_en(wr_en), .lane(lane), .kind(kind),
    .wr_data(wr_data), .masks(masks)
  );

  assign mask_lo = masks[DATA_W-1:0];
  assign mask_hi = masks[2*DATA_W-1:DATA_W];

  // Read source is chosen at the strobe edge and applied to the RAM output
  always_ff @(posedge clk) begin
    if (clear) begin
      src_q     <= RS_ZERO;
      ver_q     <= 1'b0;
      mask_rd_q <= '0;
    end else if (rd_en) begin
      ver_q     <= in_range && idx == IDX_W'(IX_VERSION);
      mask_rd_q <= lane ? mask_hi : mask_lo;
      case (kind)
        K_LOAD:  src_q <= RS_MASK;
        K_NONE:  src_q <= RS_ZERO;
        default: src_q <= RS_STORE;
      endcase
    end
  end

  always_comb begin
    case (src_q)
      RS_MASK:  rd_data = mask_rd_q;
      RS_STORE: rd_data = st_valid ? st_word :
                          (ver_q ? DATA_W'(VERSION_WORD) : '0);
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/svc_master_regs_chk.sv
module svc_master_regs_chk
  import svc_regs_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 185
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] word_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] mask_lo,
  input logic [DATA_W-1:0] mask_hi
);
  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en));

  assert_load_lo_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en && word_addr == ADDR_W'(IX_MASK_LO) |=> mask_lo == $past(wr_data));

  assert_set_hi_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en && word_addr == ADDR_W'(IX_SET_HI) |=>
      mask_hi == ($past(mask_hi) | $past(wr_data)));

  assert_clr_lo_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en && word_addr == ADDR_W'(IX_CLR_LO) |=>
      mask_lo == ($past(mask_lo) & ~$past(wr_data)));

  assert_self_reset_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en && word_addr == ADDR_W'(IX_RST_CMD) &&
      (wr_data[DATA_W-1] || wr_data[DATA_W-2]) |=>
      mask_lo == '0 && mask_hi == '0);

  assert_stat_zero_R9: assert property (@(posedge clk) disable iff (rst)
    rd_en && word_addr == ADDR_W'(IX_RST_STAT) |=> rd_data == '0);

  assert_out_of_range_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en && word_addr >= ADDR_W'(NUM_WORDS) |=> rd_data == '0);
endmodule

bind svc_master_regs svc_master_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)
) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .word_addr(word_addr),
  .wr_data(wr_data), .rd_data(rd_data), .mask_lo(mask_lo), .mask_hi(mask_hi)
);

// File: tb/svc_master_regs_test.sv
`timescale 1ns/1ps
module svc_master_regs_test;
  localparam int          NW  = 185;
  localparam logic [31:0] VER = 32'hE005_0101;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [9:0]  word_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] model [NW];

  svc_master_regs uut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
    .word_addr(word_addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  task automatic model_reset();
    for (int i = 0; i < NW; i++) model[i] = 32'h0;
    model[29] = VER;
  endtask

  function automatic string tag_of(int a);
    if (a >= NW) return "R10";
    case (a)
      4, 5:       return "R2";
      6, 7, 8, 9: return "R5";
      52:         return "R9";
      116:        return "R8";
      default:    return "R7";
    endcase
  endfunction

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; word_addr = 10'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < NW) begin
      case (a)
        4, 5: model[a] = d;
        6:    model[4] = model[4] | d;
        7:    model[5] = model[5] | d;
        8:    model[4] = model[4] & ~d;
        9:    model[5] = model[5] & ~d;
        52:   ;
        116:  if (d[31] || d[30]) model_reset();
        default: model[a] = d;
      endcase
    end
  endtask

  // Read sampled one falling edge after the strobe (R1 latency)
  task automatic rd_chk(int a, string tag);
    logic [31:0] exp;
    exp = (a < NW) ? model[a] : 32'h0;
    @(negedge clk);
    rd_en = 1'b1; word_addr = 10'(a);
    @(negedge clk);
    rd_en = 1'b0;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s: index %0d read %h expected %h", tag, a, rd_data, exp);
    end
  endtask

  function automatic logic [31:0] pat(int a);
    logic [7:0] b;
    b = 8'(a);
    return {b, ~b, 8'h5A, b ^ 8'hC3};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // Reset state of every word (R6), one-cycle read latency (R1)
    for (int a = 0; a < NW; a++) rd_chk(a, (a == 29 || a == 0) ? "R6" : "R1");
    rd_chk(185, "R10"); rd_chk(300, "R10"); rd_chk(1023, "R10");

    // Fill every in-range word; the command word keeps its top bits low
    for (int a = 0; a < NW; a++) begin
      logic [31:0] d;
      d = pat(a);
      if (a == 116) d = d & 32'h3FFF_FFFF;
      wr(a, d);
    end
    // Out-of-range writes, some aliasing the mask indices in low bits (R10)
    wr(185, 32'hFFFF_FFFF); wr(261, 32'hDEAD_BEEF); wr(260, 32'h1234_5678);
    wr(1023, 32'hFFFF_FFFF); wr(512 + 29, 32'h0BAD_0BAD);
    for (int a = 0; a < NW; a++) rd_chk(a, tag_of(a));
    rd_chk(186, "R10"); rd_chk(261, "R10");

    // Mask load, set and clear on both lanes (R2, R3, R4)
    wr(4, 32'hF0F0_0000); rd_chk(4, "R2");
    wr(6, 32'h0000_00FF); rd_chk(4, "R3");
    wr(8, 32'hF000_000F); rd_chk(4, "R4");
    wr(8, 32'hFFFF_FFFF); rd_chk(4, "R4");
    wr(5, 32'h0000_0001); rd_chk(5, "R2");
    wr(7, 32'h8000_0000); rd_chk(5, "R3");
    wr(7, 32'h8000_0001); rd_chk(5, "R3");
    wr(9, 32'h0000_0001); rd_chk(5, "R4");
    rd_chk(4, "R4");
    for (int a = 6; a < 10; a++) rd_chk(a, "R5");
    wr(52, 32'hFFFF_FFFF); rd_chk(52, "R9");

    // Version is writable, then restored by a command reset (R7, R8)
    wr(29, 32'h1234_5678); rd_chk(29, "R7");
    wr(116, 32'h8000_0000);
    for (int a = 0; a < NW; a++) rd_chk(a, a == 29 ? "R6" : "R8");

    // Error-reset bit alone also clears everything (R8)
    wr(4, 32'hAAAA_5555); wr(5, 32'h5555_AAAA); wr(100, 32'hCAFE_F00D);
    wr(116, 32'h4000_0000);
    rd_chk(4, "R8"); rd_chk(5, "R8"); rd_chk(100, "R8"); rd_chk(29, "R8");

    // External reset restores the reset image (R6)
    wr(10, 32'h0000_1111); wr(4, 32'h0000_2222);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    model_reset();
    for (int a = 0; a < NW; a++) rd_chk(a, "R6");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule